// File: doc/BRIEF.md
# Power Domain Module State Controller

This block sequences a single peripheral module of one power domain between four clock and reset states, under control of an external host. The host uses a small memory-mapped register port (read strobe, write strobe, shared address, write data, read data) to stage a requested state and then commit it with a separate go command. The controller drives the module's clock enable and active-low module reset and reports progress through a domain busy bit and a per-module current-state field.

A change of state always takes two host writes. The host first polls the busy bit until it reads 0, writes the requested code into the control register, and then writes the go bit. The clock enable moves to the new state's value at the start of the transition. The module reset, the busy bit and the reported state all change together after a fixed number of cycles, set by the `TRANS_CYCLES` parameter (4 or more). The module under control cannot act on the controller; only the host port can.

Top module: `pwr_mod_ctrl`

## Requirements
- R1: After reset the current state and the staged state are both 3 (enable), the busy bit is 0, `mod_clk_en` is 1 and `mod_rst_n` is 1.
- R2: A write of 0 to 3 to the control register (offset 0, code in bits [1:0]) is read back from that register and changes neither the outputs nor the status register until go is issued. A staging write made while busy does not alter the transition in progress.
- R3: A write to the control register whose full data value is 4 or more is ignored, and the staged code keeps its previous value.
- R4: A write to the command register (offset 2) with bit 0 set while idle makes the busy bit read 1 from the next cycle, and at that same edge `mod_clk_en` takes the clock value of the staged state.
- R5: The busy bit (transition-status register, offset 3, bit 0) stays 1 for exactly `TRANS_CYCLES` cycles. The status register (offset 1, bits [1:0]) shows the old state until the edge at which busy clears, and then shows the new state.
- R6: `mod_rst_n` holds its old value for the whole transition and takes the new state's reset value at the edge where busy clears.
- R7: A go write while busy is ignored. It neither restarts nor extends the transition, and it does not retarget it.
- R8: State codes map to outputs as follows: 0 gives clock on with reset asserted, 1 gives clock off with reset asserted, 2 (disable) gives clock off with reset released, and 3 gives clock on with reset released.
- R9: A command-register write with bit 0 clear starts nothing, and the command register always reads 0.
- R10: Reads are combinational in the cycle of the read strobe. `reg_rd_data` is 0 when the strobe is low or the address is not one of offsets 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_data | output | DATA_W | Read data, valid while the read strobe is high |
| mod_clk_en | output | 1 | Clock enable for the controlled module |
| mod_rst_n | output | 1 | Active-low reset for the controlled module |

## Verification
The bench probes the register status one cycle before and one cycle at the end of each transition. A design that counted one cycle too many or too few, or that published the new state early, fails at one of those two points. A second go is issued mid-transition together with a fresh staged code. A controller that restarted its counter would stay busy too long, and one that re-latched the target would settle in the wrong state. Out-of-range control codes and go writes with bit 0 clear are also applied, so a decoder that trusted only the low bits, or one that started on any command write, would change the outputs when it should not.

// File: rtl/pmc_pkg.sv
// Package pmc_pkg
// Shared state encoding, register offsets and the per-state output mapping
// for the power domain module state controller.
// Assumes a two-bit state code. Wider staged values are rejected by the
// register decoder.
package pmc_pkg;

    typedef enum logic [1:0] {
        ST_SYNCRST = 2'd0,   // clock running, reset asserted
        ST_RSTOFF  = 2'd1,   // clock stopped, reset asserted
        ST_DISABLE = 2'd2,   // clock stopped, reset released
        ST_ENABLE  = 2'd3    // clock running, reset released
    } mod_state_e;

    localparam int unsigned OFS_CTL   = 0;
    localparam int unsigned OFS_STAT  = 1;
    localparam int unsigned OFS_CMD   = 2;
    localparam int unsigned OFS_XSTAT = 3;

    // True when the module clock runs in the given state
    function automatic logic state_clk_on(mod_state_e s);
        return (s == ST_SYNCRST) || (s == ST_ENABLE);
    endfunction

    // True when the module reset is asserted in the given state
    function automatic logic state_rst_on(mod_state_e s);
        return (s == ST_SYNCRST) || (s == ST_RSTOFF);
    endfunction

endpackage

// File: rtl/pmc_regs.sv
// Module pmc_regs
// Host register file: holds the staged state, decodes the go command into a
// single-cycle request and serves combinational reads.
// Assumes one access per strobe. The go request is a pulse that the
// sequencer alone decides to accept or drop.
module pmc_regs
    import pmc_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  mod_state_e        cur_state,
    input  logic              busy,
    output mod_state_e        staged,
    output logic              go_req,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [DATA_W-1:0] CODE_LIMIT = DATA_W'(4);

    logic hit_ctl, hit_stat, hit_cmd, hit_xstat;

    // Address decode for the four registers
    always_comb begin
        hit_ctl   = (addr == ADDR_W'(OFS_CTL));
        hit_stat  = (addr == ADDR_W'(OFS_STAT));
        hit_cmd   = (addr == ADDR_W'(OFS_CMD));
        hit_xstat = (addr == ADDR_W'(OFS_XSTAT));
    end

    // Staged requested state; out-of-range values leave it untouched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= ST_ENABLE;
        end else if (wr_en && hit_ctl && (wr_data < CODE_LIMIT)) begin
            staged <= mod_state_e'(wr_data[1:0]);
        end
    end

    // Go request pulse from a command write with bit 0 set
    always_comb begin
        go_req = wr_en && hit_cmd && wr_data[0];
    end

    // Read multiplexer, zero when not strobed or unmapped
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (hit_ctl)        rd_data = DATA_W'(staged);
            else if (hit_stat)  rd_data = DATA_W'(cur_state);
            else if (hit_xstat) rd_data = DATA_W'(busy);
            else                rd_data = '0;
        end
    end

endmodule

// File: rtl/pmc_seq.sv
// Module pmc_seq
// Transition sequencer: accepts a go request when idle, moves the clock
// enable at once, counts TRANS_CYCLES cycles, then releases busy and
// publishes the new state and reset level together.
// Assumes TRANS_CYCLES >= 4. Requests arriving while busy are dropped.
module pmc_seq
    import pmc_pkg::*;
#(
    parameter int unsigned TRANS_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_req,
    input  mod_state_e staged,
    output logic       busy,
    output mod_state_e cur_state,
    output logic       clk_en,
    output logic       mod_rst_n
);

    localparam int unsigned CNT_W   = (TRANS_CYCLES > 2) ? $clog2(TRANS_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TRANS_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    mod_state_e       target_q;

    // Transition state machine with its cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt_q     <= '0;
            target_q  <= ST_ENABLE;
            cur_state <= ST_ENABLE;
            clk_en    <= 1'b1;
            mod_rst_n <= 1'b1;
        end else if (!busy) begin
            if (go_req) begin
                busy     <= 1'b1;
                cnt_q    <= CNT_LOAD;
                target_q <= staged;
                clk_en   <= state_clk_on(staged);
            end
        end else if (cnt_q == '0) begin
            busy      <= 1'b0;
            cur_state <= target_q;
            mod_rst_n <= !state_rst_on(target_q);
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/pwr_mod_ctrl.sv
// Module pwr_mod_ctrl
// Top of the power domain module state controller: host register port plus
// transition sequencer driving one module's clock enable and reset.
// Assumes a single power domain with a single controlled module.
module pwr_mod_ctrl
    import pmc_pkg::*;
#(
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned TRANS_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic              mod_clk_en,
    output logic              mod_rst_n
);

    mod_state_e staged;
    mod_state_e cur_state;
    logic       go_req;
    logic       busy;

    pmc_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .rd_en     (reg_rd_en),
        .addr      (reg_addr),
        .wr_data   (reg_wr_data),
        .cur_state (cur_state),
        .busy      (busy),
        .staged    (staged),
        .go_req    (go_req),
        .rd_data   (reg_rd_data)
    );

    pmc_seq #(
        .TRANS_CYCLES (TRANS_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_req    (go_req),
        .staged    (staged),
        .busy      (busy),
        .cur_state (cur_state),
        .clk_en    (mod_clk_en),
        .mod_rst_n (mod_rst_n)
    );

endmodule

// File: rtl/pmc_chk.sv
// Module pmc_chk
// Protocol checker bound into pwr_mod_ctrl. It watches the go request, the
// busy flag, the published state and the module outputs.
// Assumes a synchronous active-low reset. The busy run length is measured
// with a counter so that the window does not depend on a parameter delay.
module pmc_chk #(
    parameter int unsigned TRANS_CYCLES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       go_req,
    input logic       busy,
    input logic [1:0] cur_state,
    input logic       mod_clk_en,
    input logic       mod_rst_n
);

    logic [31:0] run_q;

    // Count consecutive sampled busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= '0;
    end

    assert_go_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (go_req && !busy) |=> busy);

    assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == TRANS_CYCLES));

    assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < TRANS_CYCLES));

    assert_state_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cur_state));

    assert_reset_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mod_rst_n));

    assert_clk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mod_clk_en));

    assert_disable_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cur_state == 2'd2) |-> (!mod_clk_en && mod_rst_n));

endmodule

bind pwr_mod_ctrl pmc_chk #(
    .TRANS_CYCLES (TRANS_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_req     (go_req),
    .busy       (busy),
    .cur_state  (cur_state),
    .mod_clk_en (mod_clk_en),
    .mod_rst_n  (mod_rst_n)
);

// File: tb/pwr_mod_ctrl_tb.sv
// Bench for pwr_mod_ctrl: a table of target codes with expected outputs,
// walked by one loop, then directed checks for reset and corner cases.
module pwr_mod_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TRANS      = 8;
    localparam int AW         = 4;
    localparam int DW         = 32;

    // Entry: [7:5] code written, [4] clock on, [3] reset released, [1:0] state
    localparam logic [7:0] VECS [0:7] = '{
        8'h4A, 8'h7B, 8'h21, 8'hC1, 8'h10, 8'h4A, 8'h4A, 8'h7B
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic          reg_rd_en = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wr_data = '0;
    logic [DW-1:0] reg_rd_data;
    logic          mod_clk_en;
    logic          mod_rst_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    pwr_mod_ctrl #(
        .ADDR_W       (AW),
        .DATA_W       (DW),
        .TRANS_CYCLES (TRANS)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_rd_en   (reg_rd_en),
        .reg_addr    (reg_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .mod_clk_en  (mod_clk_en),
        .mod_rst_n   (mod_rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        reg_addr    = a;
        reg_wr_data = d;
        reg_wr_en   = 1'b1;
        @(posedge clk);
        #1;
        reg_wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_addr  = a;
        reg_rd_en = 1'b1;
        #1;
        d = reg_rd_data;
        reg_rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [DW-1:0] v;
        rd(4'd3, v);
        while (v[0]) begin
            @(posedge clk);
            #1;
            rd(4'd3, v);
        end
    endtask

    initial begin
        logic [DW-1:0] v;
        logic [1:0]    prev_st;
        logic          prev_rstn;

        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R1: reset values
        rd(4'd0, v); chk("R1 staged", v, 32'd3);
        rd(4'd1, v); chk("R1 status", v, 32'd3);
        rd(4'd3, v); chk("R1 busy", v, 32'd0);
        chk("R1 clk_en", {31'd0, mod_clk_en}, 32'd1);
        chk("R1 rst_n", {31'd0, mod_rst_n}, 32'd1);

        // R10: no strobe gives zero
        reg_addr = 4'd1; #1;
        chk("R10 no strobe", reg_rd_data, 32'd0);

        prev_st   = 2'd3;
        prev_rstn = 1'b1;
        for (int i = 0; i < 8; i++) begin
            logic [2:0] code;
            logic       e_clk, e_rstn;
            logic [1:0] e_st;
            code   = VECS[i][7:5];
            e_clk  = VECS[i][4];
            e_rstn = VECS[i][3];
            e_st   = VECS[i][1:0];
            wait_idle();
            wr(4'd0, {29'd0, code});
            rd(4'd0, v); chk("R2/R3 staged readback", v, {30'd0, e_st});
            rd(4'd1, v); chk("R2 status before go", v, {30'd0, prev_st});
            wr(4'd2, 32'd1);
            rd(4'd3, v); chk("R4 busy after go", v, 32'd1);
            chk("R4/R8 clk_en at start", {31'd0, mod_clk_en}, {31'd0, e_clk});
            rd(4'd1, v); chk("R5 status old at start", v, {30'd0, prev_st});
            repeat (TRANS - 1) @(posedge clk);
            #1;
            rd(4'd3, v); chk("R5 busy last cycle", v, 32'd1);
            rd(4'd1, v); chk("R5 status old last cycle", v, {30'd0, prev_st});
            chk("R6 rst_n held", {31'd0, mod_rst_n}, {31'd0, prev_rstn});
            @(posedge clk);
            #1;
            rd(4'd3, v); chk("R5 busy cleared", v, 32'd0);
            rd(4'd1, v); chk("R5 status new", v, {30'd0, e_st});
            chk("R6/R8 rst_n new", {31'd0, mod_rst_n}, {31'd0, e_rstn});
            chk("R8 clk_en new", {31'd0, mod_clk_en}, {31'd0, e_clk});
            prev_st   = e_st;
            prev_rstn = e_rstn;
        end

        // R7: go and restage while busy; state is 3 here
        wait_idle();
        wr(4'd0, 32'd2);
        wr(4'd2, 32'd1);
        repeat (2) @(posedge clk);
        #1;
        wr(4'd0, 32'd1);
        wr(4'd2, 32'd1);
        repeat (TRANS - 5) @(posedge clk);
        #1;
        rd(4'd3, v); chk("R7 busy last cycle", v, 32'd1);
        chk("R7 clk_en kept", {31'd0, mod_clk_en}, 32'd0);
        @(posedge clk);
        #1;
        rd(4'd3, v); chk("R7 busy not extended", v, 32'd0);
        rd(4'd1, v); chk("R7 target kept", v, 32'd2);
        chk("R7 rst_n", {31'd0, mod_rst_n}, 32'd1);
        rd(4'd0, v); chk("R2 restage while busy", v, 32'd1);

        // R3: large value with legal low bits ignored
        wr(4'd0, 32'h0000_0103);
        rd(4'd0, v); chk("R3 wide value ignored", v, 32'd1);

        // R9: command with bit 0 clear
        wr(4'd2, 32'hFFFF_FFFE);
        rd(4'd3, v); chk("R9 no start", v, 32'd0);
        repeat (2) @(posedge clk);
        #1;
        rd(4'd3, v); chk("R9 still idle", v, 32'd0);
        chk("R9 clk_en unchanged", {31'd0, mod_clk_en}, 32'd0);
        rd(4'd2, v); chk("R9 cmd reads zero", v, 32'd0);

        // R10: unmapped offset
        rd(4'd7, v); chk("R10 unmapped", v, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule